// File: doc/BRIEF.md
# Timestamped trigger event capture

This block watches a small set of asynchronous external trigger lines, brings them into the local clock domain and keeps a live picture of their levels. It also owns a free-running time counter; the same count is driven out so that other logic, such as the video frame stamping path, can stamp its own data from one shared time base. Trigger events can therefore be matched against frames.

It works in one of two modes, chosen by `bufMode`. In level mode (`bufMode` = 0) the status word shows the synchronized level of each line and nothing else happens. In event mode (`bufMode` = 1) every change on a line, rising or falling, becomes an event record. A record holds a status word and the time at which the change was seen, and it leaves the block over a valid/ready handshake. Changes that arrive while a record is still waiting are gathered into a single follow-up record. The status word always carries both the pending bits and the level bits, whichever mode is active.

The status word is 8 bits wide. Its layout is fixed, and the lines supported range from 1 to 3.

Top module: `trig_capture`

## Requirements
- R1: `timeNow` is 0 while reset is held and increases by exactly 1 on every clock edge after reset is released, wrapping at its width.
- R2: Each trigger line passes through two synchronizing flops. The level bit for line i reflects `trigIn[i]` as it was two clock edges earlier, in both modes.
- R3: Status word layout: bit 1+i is the pending flag of line i and bit 5+i is the level of line i. So with two lines, bits 1 and 2 are pending and bits 5 and 6 are level. Every other bit reads 0.
- R4: In level mode no record is produced and all pending bits read 0. Switching to level mode discards any waiting record or gathered events on the next edge.
- R5: In event mode, a rising or falling change on a line raises `evtValid` one edge after the new level first shows in the status word. `evtStatus` has that line's pending bit set and holds the current levels. `evtStamp` equals the `timeNow` value shown in the cycle when the new level first appeared.
- R6: Changes on several lines in the same cycle give one record with all of their pending bits set.
- R7: While `evtValid` is high and `evtReady` is low, the record (`evtValid`, `evtStatus`, `evtStamp`) stays unchanged. A record is accepted on an edge where both are high, and its pending bits clear from the status word on that edge.
- R8: Changes seen while a record is waiting are gathered into one follow-up record. Its pending bits show in `statusWord` at once, and it is stamped with the time of the first of those changes. It becomes `evtValid` on the edge that accepts the earlier record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | NUM_TRIG | Asynchronous trigger lines |
| bufMode | input | 1 | 0 = level mode, 1 = event mode |
| evtReady | input | 1 | Consumer accepts the current record |
| timeNow | output | TS_W | Free-running shared time count |
| statusWord | output | 8 | Live pending and level bits |
| evtValid | output | 1 | A record is offered |
| evtStatus | output | 8 | Status word of the offered record |
| evtStamp | output | TS_W | Time stamp of the offered record |

## Verification
The properties assume that `trigIn`, `bufMode` and `evtReady` change only away from the active clock edge. The level check assumes each trigger level comes straight from the line two edges earlier. The bench drives every input a short delay after a rising edge, so each value is sampled cleanly at the next edge. Trigger lines are changed only in controlled steps whose arrival cycle is known. The level-tracking property assumes the synchronizer depth stays at its default of two.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int STATUS_W = 8;
  localparam int PEND_LSB = 1;
  localparam int LVL_LSB  = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic slotFromBack;  // load offered record from gathered events
    logic slotFromEdge;  // load offered record from this cycle's changes
    logic slotClear;     // empty the offered record
    logic backCapture;   // merge this cycle's changes into gathered set
    logic backStampLoad; // gathered set was empty: take stamp now
    logic backClear;     // empty gathered set
  } ctlStrobe_t;
endpackage

// File: rtl/trig_control.sv
module trig_control
  import trig_pkg::*;
(
  input  logic       bufMode,
  input  logic       edgeAny,
  input  logic       slotFull,
  input  logic       backFull,
  input  logic       evtReady,
  output ctlStrobe_t ctl
);
  logic accept;
  logic slotFree;

  assign accept   = slotFull & evtReady;
  assign slotFree = ~slotFull | accept;

  always_comb begin
    ctl = '0;
    if (!bufMode) begin
      ctl.slotClear = 1'b1;
      ctl.backClear = 1'b1;
    end else if (slotFree) begin
      if (backFull) begin
        ctl.slotFromBack = 1'b1;
        ctl.backClear    = 1'b1;
      end else if (edgeAny) begin
        ctl.slotFromEdge = 1'b1;
      end else if (accept) begin
        ctl.slotClear = 1'b1;
      end
    end else if (edgeAny) begin
      ctl.backCapture   = 1'b1;
      ctl.backStampLoad = ~backFull;
    end
  end
endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int NUM_TRIG   = 2,
  parameter int TS_W       = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  ctlStrobe_t          ctl,
  output logic                edgeAny,
  output logic                slotFull,
  output logic                backFull,
  output logic [TS_W-1:0]     timeNow,
  output logic [STATUS_W-1:0] statusWord,
  output logic [STATUS_W-1:0] evtStatus,
  output logic [TS_W-1:0]     evtStamp
);
  logic [NUM_TRIG-1:0] syncStage [SYNC_DEPTH];
  logic [NUM_TRIG-1:0] lvl, prevLvl, edgeMask;
  logic [TS_W-1:0]     counter;
  logic [NUM_TRIG-1:0] slotMask, slotLvl, backMask;
  logic [TS_W-1:0]     slotStamp, backStamp;

  // synchronizer chain
  genvar g;
  generate
    for (g = 0; g < SYNC_DEPTH; g++) begin : gSync
      always_ff @(posedge clk) begin
        if (!rstN) syncStage[g] <= '0;
        else if (g == 0) syncStage[g] <= trigIn;
        else syncStage[g] <= syncStage[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign lvl = syncStage[SYNC_DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLvl <= '0;
      counter <= '0;
    end else begin
      prevLvl <= lvl;
      counter <= counter + TS_W'(1);
    end
  end

  assign edgeMask = lvl ^ prevLvl;
  assign edgeAny  = |edgeMask;

  // offered record
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotMask  <= '0;
      slotLvl   <= '0;
      slotStamp <= '0;
    end else if (ctl.slotFromBack) begin
      slotMask  <= backMask | edgeMask;
      slotLvl   <= lvl;
      slotStamp <= backStamp;
    end else if (ctl.slotFromEdge) begin
      slotMask  <= edgeMask;
      slotLvl   <= lvl;
      slotStamp <= counter;
    end else if (ctl.slotClear) begin
      slotMask <= '0;
    end
  end

  // gathered events waiting behind the offered record
  always_ff @(posedge clk) begin
    if (!rstN) begin
      backMask  <= '0;
      backStamp <= '0;
    end else if (ctl.backClear) begin
      backMask <= '0;
    end else if (ctl.backCapture) begin
      backMask <= backMask | edgeMask;
      if (ctl.backStampLoad) backStamp <= counter;
    end
  end

  assign slotFull = |slotMask;
  assign backFull = |backMask;
  assign timeNow  = counter;
  assign evtStamp = slotStamp;

  always_comb begin
    statusWord = '0;
    evtStatus  = '0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      statusWord[PEND_LSB+i] = slotMask[i] | backMask[i];
      statusWord[LVL_LSB+i]  = lvl[i];
      evtStatus[PEND_LSB+i]  = slotMask[i];
      evtStatus[LVL_LSB+i]   = slotLvl[i];
    end
  end
endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import trig_pkg::*;
#(
  parameter int NUM_TRIG   = 2,
  parameter int TS_W       = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  logic                bufMode,
  input  logic                evtReady,
  output logic [TS_W-1:0]     timeNow,
  output logic [STATUS_W-1:0] statusWord,
  output logic                evtValid,
  output logic [STATUS_W-1:0] evtStatus,
  output logic [TS_W-1:0]     evtStamp
);
  ctlStrobe_t ctl;
  logic edgeAny, slotFull, backFull;

  trig_control u_control (
    .bufMode  (bufMode),
    .edgeAny  (edgeAny),
    .slotFull (slotFull),
    .backFull (backFull),
    .evtReady (evtReady),
    .ctl      (ctl)
  );

  trig_datapath #(
    .NUM_TRIG   (NUM_TRIG),
    .TS_W       (TS_W),
    .SYNC_DEPTH (SYNC_DEPTH)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .trigIn     (trigIn),
    .ctl        (ctl),
    .edgeAny    (edgeAny),
    .slotFull   (slotFull),
    .backFull   (backFull),
    .timeNow    (timeNow),
    .statusWord (statusWord),
    .evtStatus  (evtStatus),
    .evtStamp   (evtStamp)
  );

  assign evtValid = slotFull;
endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk
  import trig_pkg::*;
#(
  parameter int NUM_TRIG = 2,
  parameter int TS_W     = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_TRIG-1:0] trigIn,
  input logic                bufMode,
  input logic                evtReady,
  input logic [TS_W-1:0]     timeNow,
  input logic [STATUS_W-1:0] statusWord,
  input logic                evtValid,
  input logic [STATUS_W-1:0] evtStatus,
  input logic [TS_W-1:0]     evtStamp
);
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> timeNow == $past(timeNow) + TS_W'(1)); // R1

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2)) |->
      statusWord[LVL_LSB +: NUM_TRIG] == $past(trigIn, 2)); // R2

  AST_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !bufMode |=> (!evtValid && statusWord[PEND_LSB +: NUM_TRIG] == '0)); // R4

  AST_CHANGE_RECORD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && bufMode && !evtValid &&
     statusWord[LVL_LSB +: NUM_TRIG] != $past(statusWord[LVL_LSB +: NUM_TRIG]))
      |=> evtValid); // R5

  AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtReady && bufMode) |=>
      (evtValid && $stable(evtStatus) && $stable(evtStamp))); // R7

  AST_PEND_COVER: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> ((evtStatus[PEND_LSB +: NUM_TRIG] &
                   ~statusWord[PEND_LSB +: NUM_TRIG]) == '0)); // R8
endmodule

bind trig_capture trig_capture_chk #(.NUM_TRIG(NUM_TRIG), .TS_W(TS_W)) u_chk (.*);

// File: tb/test_trig_capture.sv
`timescale 1ns/1ps
module test_trig_capture;
  localparam int NT = 2;
  localparam int TW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NT-1:0] trigIn;
  logic          bufMode;
  logic          evtReady;
  logic [TW-1:0] timeNow;
  logic [7:0]    statusWord;
  logic          evtValid;
  logic [7:0]    evtStatus;
  logic [TW-1:0] evtStamp;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  trig_capture #(.NUM_TRIG(NT), .TS_W(TW)) i_trig_capture (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .bufMode(bufMode),
    .evtReady(evtReady), .timeNow(timeNow), .statusWord(statusWord),
    .evtValid(evtValid), .evtStatus(evtStatus), .evtStamp(evtStamp)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // advance to a point just after the next rising edge
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic acceptNow();
    evtReady = 1'b1;
    step();
    evtReady = 1'b0;
  endtask

  task automatic testReset();
    logic [TW-1:0] t0;
    check("R3", "status after reset", statusWord, 8'h00);
    check("R4", "valid after reset", evtValid, 1'b0);
    t0 = timeNow;
    step();
    check("R1", "time step", timeNow, t0 + 1);
    step();
    check("R1", "time step 2", timeNow, t0 + 2);
  endtask

  task automatic testLevelMode();
    bufMode = 1'b0;
    step();
    trigIn = 2'b01;
    step();
    check("R2", "level not yet after one edge", statusWord, 8'h00);
    step();
    check("R2", "level after two edges", statusWord, 8'h20);
    step();
    check("R4", "no record in level mode", evtValid, 1'b0);
    step();
    check("R4", "no pending in level mode", statusWord, 8'h20);
    trigIn = 2'b00;
    step(); step(); step();
    check("R2", "level fall seen", statusWord, 8'h00);
    check("R4", "still no record", evtValid, 1'b0);
  endtask

  task automatic testRise();
    logic [TW-1:0] t;
    bufMode = 1'b1;
    step();
    trigIn = 2'b01;
    step(); step();
    t = timeNow;
    check("R5", "no record before detect edge", evtValid, 1'b0);
    step();
    check("R5", "rise record valid", evtValid, 1'b1);
    check("R5", "rise record status", evtStatus, 8'h22);
    check("R5", "rise record stamp", evtStamp, t);
    check("R3", "live status with pending", statusWord, 8'h22);
    step(); step(); step();
    check("R7", "record held valid", evtValid, 1'b1);
    check("R7", "record held status", evtStatus, 8'h22);
    check("R7", "record held stamp", evtStamp, t);
    acceptNow();
    check("R7", "valid drops after accept", evtValid, 1'b0);
    check("R7", "pending cleared after accept", statusWord, 8'h20);
  endtask

  task automatic testFall();
    logic [TW-1:0] t;
    trigIn = 2'b00;
    step(); step();
    t = timeNow;
    step();
    check("R5", "fall record status", evtStatus, 8'h02);
    check("R5", "fall record stamp", evtStamp, t);
    acceptNow();
    check("R7", "fall accepted", statusWord, 8'h00);
  endtask

  task automatic testBoth();
    logic [TW-1:0] t;
    trigIn = 2'b11;
    step(); step();
    t = timeNow;
    step();
    check("R6", "joint record status", evtStatus, 8'h66);
    check("R6", "joint record stamp", evtStamp, t);
    acceptNow();
    check("R6", "single joint record", evtValid, 1'b0);
    check("R6", "joint accepted status", statusWord, 8'h60);
  endtask

  task automatic testGather();
    logic [TW-1:0] t1, t2;
    trigIn = 2'b01;
    step(); step();
    t1 = timeNow;
    step();
    check("R5", "first record status", evtStatus, 8'h24);
    trigIn = 2'b00;
    step(); step();
    t2 = timeNow;
    step();
    check("R8", "gathered pending visible", statusWord, 8'h06);
    check("R7", "first record unchanged", evtStatus, 8'h24);
    check("R7", "first stamp unchanged", evtStamp, t1);
    evtReady = 1'b1;
    step();
    check("R8", "follow-up valid", evtValid, 1'b1);
    check("R8", "follow-up status", evtStatus, 8'h02);
    check("R8", "follow-up stamp", evtStamp, t2);
    check("R7", "first pending cleared", statusWord, 8'h02);
    step();
    evtReady = 1'b0;
    check("R8", "follow-up accepted", evtValid, 1'b0);
    check("R8", "all pending clear", statusWord, 8'h00);
  endtask

  task automatic testDiscard();
    trigIn = 2'b01;
    step(); step(); step();
    check("R5", "record before discard", evtValid, 1'b1);
    bufMode = 1'b0;
    step();
    check("R4", "record discarded", evtValid, 1'b0);
    check("R4", "pending discarded", statusWord, 8'h20);
    bufMode = 1'b1;
    step(); step();
    check("R4", "no stale record", evtValid, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; trigIn = '0; bufMode = 1'b0; evtReady = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
    step();
    testReset();
    testLevelMode();
    testRise();
    testFall();
    testBoth();
    testGather();
    testDiscard();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule